// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block lets supervisor software schedule its own timer interrupt without calling up to machine mode. It holds a 64-bit compare value that software reaches as two 32-bit CSR halves, one for the low word and one for the high word. The block compares that value, unsigned, against the free-running 64-bit time bus, which is the same bus that the time-read instruction uses. It drives a supervisor timer-pending level that stays high for as long as time is at or past the compare value.

The pending output has no acknowledge input. Software removes a pending interrupt only by moving the compare value beyond the current time. A handler that advances the value and returns at once may therefore take one extra trap, because the registered level can still be high for a cycle. Machine mode may always reach the halves. Supervisor mode may reach them only when the machine-level enable input is high. Any other access is flagged as illegal and has no effect.

Top module: `sup_timer_cmp`

## Requirements
- R1: After reset both compare halves read as 32'hFFFF_FFFF and `stip_o` is 0.
- R2: A legal write with `csr_hi_i`=0 replaces bits 31:0 of the compare value on the next clock edge and leaves bits 63:32 unchanged.
- R3: A legal write with `csr_hi_i`=1 replaces bits 63:32 of the compare value on the next clock edge and leaves bits 31:0 unchanged.
- R4: `stip_o` is registered. On each clock edge it loads the result of (time >= compare), so it reflects the compare result one cycle late.
- R5: `stip_o` goes high when time equals the compare value exactly.
- R6: The comparison is unsigned. A time value with bit 63 set is greater than a compare value with bit 63 clear.
- R7: An access with `priv_i`=2'b11 (machine) is always legal, whatever the value of `menv_en_i`.
- R8: An access with `priv_i`=2'b01 (supervisor) is legal only when `menv_en_i`=1. Otherwise `csr_illegal_o` is 1, the write is dropped and `csr_rdata_o` is 0.
- R9: An access with `priv_i`=2'b00 (user) or 2'b10 is always illegal. `csr_illegal_o` is 1, the write is dropped and `csr_rdata_o` is 0.
- R10: There is no acknowledge path. Once pending, `stip_o` stays high until a write makes the compare value greater than time, and it falls on the edge after the edge that applied that write.
- R11: `csr_rdata_o` returns the selected half combinationally during a legal read. `csr_illegal_o` is 0 whenever `csr_req_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_i | input | 64 | Shared time bus |
| csr_req_i | input | 1 | CSR access to either compare half this cycle |
| csr_we_i | input | 1 | Access is a write |
| csr_hi_i | input | 1 | 0 selects the low half, 1 selects the high half |
| csr_wdata_i | input | 32 | Write data |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| menv_en_i | input | 1 | Machine-level grant for supervisor access |
| csr_rdata_o | output | 32 | Read data for the selected half |
| stip_o | output | 1 | Supervisor timer pending level |
| csr_illegal_o | output | 1 | Current access is not permitted |

## Verification
The hardest case to reach is the clearing of a pending interrupt. Because the CSR path is only 32 bits wide, moving the compare value past time takes two writes. Between those writes the compare value is a mix of old and new halves, and that value may still sit at or below time. The stimulus first drives pending high with time above the compare value. It then writes the high half alone and checks that `stip_o` falls exactly one edge later. It also writes a low half that leaves the value below time, and checks that pending stays high. Equality is reached with a time value that sits on a carry boundary between the halves, so the check also covers the high-word comparison.

// File: rtl/sup_timer_cmp.sv
module sup_timer_cmp #(
  parameter int DW = 32,
  parameter logic [1:0] PRIV_U = 2'b00,
  parameter logic [1:0] PRIV_S = 2'b01,
  parameter logic [1:0] PRIV_M = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*DW-1:0]   time_i,
  input  logic              csr_req_i,
  input  logic              csr_we_i,
  input  logic              csr_hi_i,
  input  logic [DW-1:0]     csr_wdata_i,
  input  logic [1:0]        priv_i,
  input  logic              menv_en_i,
  output logic [DW-1:0]     csr_rdata_o,
  output logic              stip_o,
  output logic              csr_illegal_o
);
  localparam int TW = 2 * DW;

  logic [TW-1:0] cmp_q;
  logic          legal;
  logic          wr_lo;
  logic          wr_hi;

  assign legal = (priv_i == PRIV_M) || ((priv_i == PRIV_S) && menv_en_i);
  assign csr_illegal_o = csr_req_i && !legal;
  assign wr_lo = csr_req_i && legal && csr_we_i && !csr_hi_i;
  assign wr_hi = csr_req_i && legal && csr_we_i && csr_hi_i;

  assign csr_rdata_o = (csr_req_i && legal)
                     ? (csr_hi_i ? cmp_q[TW-1:DW] : cmp_q[DW-1:0])
                     : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else begin
      if (wr_lo) cmp_q[DW-1:0]  <= csr_wdata_i;
      if (wr_hi) cmp_q[TW-1:DW] <= csr_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stip_o <= 1'b0;
    else        stip_o <= (time_i >= cmp_q);
  end

  // R2
  low_write_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && !csr_illegal_o && csr_we_i && !csr_hi_i) |=>
      (cmp_q[TW-1:DW] == $past(cmp_q[TW-1:DW])) && (cmp_q[DW-1:0] == $past(csr_wdata_i)));

  // R3
  high_write_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && !csr_illegal_o && csr_we_i && csr_hi_i) |=>
      (cmp_q[DW-1:0] == $past(cmp_q[DW-1:0])) && (cmp_q[TW-1:DW] == $past(csr_wdata_i)));

  // R7
  machine_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && priv_i == 2'b11) |-> !csr_illegal_o);

  // R9
  user_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req_i && (priv_i == 2'b00 || priv_i == 2'b10)) |-> csr_illegal_o);

  // R8
  illegal_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_illegal_o && csr_we_i) |=> $stable(cmp_q));

  // R8
  illegal_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_illegal_o |-> (csr_rdata_o == '0));

  // R11
  no_req_no_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req_i |-> !csr_illegal_o);

  // R10
  pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stip_o && $stable(cmp_q) && !(csr_req_i && csr_we_i && !csr_illegal_o)
       && (time_i >= cmp_q)) |=> stip_o);
endmodule

// File: tb/test_sup_timer_cmp.sv
module test_sup_timer_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_i = '0;
  logic        csr_req_i = 1'b0;
  logic        csr_we_i = 1'b0;
  logic        csr_hi_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic [1:0]  priv_i = 2'b11;
  logic        menv_en_i = 1'b0;
  logic [31:0] csr_rdata_o;
  logic        stip_o;
  logic        csr_illegal_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sup_timer_cmp i_sup_timer_cmp (
    .clk(clk), .rst_n(rst_n), .time_i(time_i),
    .csr_req_i(csr_req_i), .csr_we_i(csr_we_i), .csr_hi_i(csr_hi_i),
    .csr_wdata_i(csr_wdata_i), .priv_i(priv_i), .menv_en_i(menv_en_i),
    .csr_rdata_o(csr_rdata_o), .stip_o(stip_o), .csr_illegal_o(csr_illegal_o)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit hi, input logic [31:0] d, input logic [1:0] pv, input bit en);
    @(negedge clk);
    csr_req_i = 1; csr_we_i = 1; csr_hi_i = hi; csr_wdata_i = d; priv_i = pv; menv_en_i = en;
    @(posedge clk); #1;
    csr_req_i = 0; csr_we_i = 0;
  endtask

  task automatic rd(input bit hi, input logic [1:0] pv, input bit en,
                    output logic [31:0] d, output logic ill);
    @(negedge clk);
    csr_req_i = 1; csr_we_i = 0; csr_hi_i = hi; priv_i = pv; menv_en_i = en;
    #1; d = csr_rdata_o; ill = csr_illegal_o;
    csr_req_i = 0;
  endtask

  task automatic set_cmp(input logic [63:0] v);
    wr(0, v[31:0], 2'b11, 0);
    wr(1, v[63:32], 2'b11, 0);
  endtask

  task automatic settle;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic ill;
    check("R1 stip after reset", stip_o, 0);
    rd(0, 2'b11, 0, d, ill); check("R1 low reset", d, 32'hFFFF_FFFF);
    rd(1, 2'b11, 0, d, ill); check("R1 high reset", d, 32'hFFFF_FFFF);
    check("R11 idle illegal", csr_illegal_o, 0);
  endtask

  task automatic t_halves;
    logic [31:0] d; logic ill;
    wr(0, 32'h1234_5678, 2'b11, 0);
    rd(0, 2'b11, 0, d, ill); check("R2 low written", d, 32'h1234_5678);
    rd(1, 2'b11, 0, d, ill); check("R2 high kept", d, 32'hFFFF_FFFF);
    wr(1, 32'h0000_00AB, 2'b11, 0);
    rd(1, 2'b11, 0, d, ill); check("R3 high written", d, 32'h0000_00AB);
    rd(0, 2'b11, 0, d, ill); check("R3 low kept", d, 32'h1234_5678);
  endtask

  task automatic t_access;
    logic [31:0] d; logic ill;
    set_cmp(64'h0000_0001_0000_0002);
    rd(0, 2'b11, 1, d, ill); check("R7 machine en=1 legal", ill, 0);
    wr(0, 32'h55, 2'b11, 0);
    rd(0, 2'b11, 0, d, ill); check("R7 machine write en=0", d, 32'h55);
    check("R7 machine en=0 legal", ill, 0);
    rd(0, 2'b01, 0, d, ill); check("R8 super en=0 illegal", ill, 1);
    check("R8 super en=0 rdata", d, 0);
    wr(0, 32'h66, 2'b01, 0);
    rd(0, 2'b01, 1, d, ill); check("R8 super en=1 legal", ill, 0);
    check("R8 super write en=0 dropped", d, 32'h55);
    wr(1, 32'h77, 2'b01, 1);
    rd(1, 2'b11, 0, d, ill); check("R8 super write en=1", d, 32'h77);
    rd(0, 2'b00, 1, d, ill); check("R9 user illegal", ill, 1);
    check("R9 user rdata", d, 0);
    wr(0, 32'h99, 2'b00, 1);
    wr(1, 32'h99, 2'b10, 1);
    rd(1, 2'b10, 1, d, ill); check("R9 priv 10 illegal", ill, 1);
    rd(0, 2'b11, 0, d, ill); check("R9 user write dropped low", d, 32'h55);
    rd(1, 2'b11, 0, d, ill); check("R9 write dropped high", d, 32'h77);
  endtask

  task automatic t_compare;
    set_cmp(64'd1000);
    time_i = 64'd999; settle;
    check("R4 below compare", stip_o, 0);
    time_i = 64'd1000;
    #1 check("R4 lag before edge", stip_o, 0);
    @(posedge clk); #1;
    check("R5 equality pending after one edge", stip_o, 1);
    time_i = 64'd999; @(posedge clk); #1;
    check("R4 falls with time below", stip_o, 0);
    set_cmp(64'h0000_0001_0000_0000);
    time_i = 64'h0000_0000_FFFF_FFFF; settle;
    check("R5 just below carry boundary", stip_o, 0);
    time_i = 64'h0000_0001_0000_0000; settle;
    check("R5 equal at carry boundary", stip_o, 1);
    set_cmp(64'h0000_0000_0000_0001);
    time_i = 64'h8000_0000_0000_0000; settle;
    check("R6 unsigned msb time", stip_o, 1);
    set_cmp(64'h8000_0000_0000_0000);
    time_i = 64'h7FFF_FFFF_FFFF_FFFF; settle;
    check("R6 unsigned msb compare", stip_o, 0);
  endtask

  task automatic t_clear;
    set_cmp(64'h0000_0002_0000_0000);
    time_i = 64'h0000_0003_0000_0000; settle;
    check("R10 pending set", stip_o, 1);
    repeat (5) @(posedge clk); #1;
    check("R10 stays without ack", stip_o, 1);
    wr(0, 32'hFFFF_FFFF, 2'b11, 0);
    check("R10 low-only write still below", stip_o, 1);
    @(posedge clk); #1;
    check("R10 still pending after low write", stip_o, 1);
    @(negedge clk);
    csr_req_i = 1; csr_we_i = 1; csr_hi_i = 1; csr_wdata_i = 32'h4; priv_i = 2'b11;
    @(posedge clk); #1;
    csr_req_i = 0; csr_we_i = 0;
    check("R10 extra cycle pending", stip_o, 1);
    @(posedge clk); #1;
    check("R10 cleared one edge after write", stip_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_halves;
    t_access;
    t_compare;
    t_clear;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule